// File: doc/BRIEF.md
# Resonant Half-Bridge Gate Drive Generator

This block drives the two primary-side switches of a half-bridge resonant converter. An external regulator supplies one unsigned demand word, and the block works out the operating mode from it. A demand at or above the programmed minimum period selects frequency control. In that mode the demand is the switching period, held inside the programmed period window, and both outputs run at half duty less the dead time. A demand below the minimum period selects duty control at the fixed minimum period. In that mode half the demand is the requested per-output on-time. When that requested on-time drops under a lower threshold, the block gates both drives off, which is burst operation. It releases them only once the request climbs above a higher threshold.

Output A conducts in the first half of each period and output B in the second half. Both use the same on-time. The on-time is capped so that at least the programmed dead time separates the fall of either output from the rise of the other. A single-clock trigger for the sampling converter marks the middle of output A's on-time in every cycle that actually switches. A fault removes the drive at once. The block stays off until the fault has gone and the enable input has been dropped and raised again.

Top module: `llc_gate_drive`

## Requirements
- R1: With demand >= t_min (frequency mode), each output is high for (P>>1) - dead consecutive clocks per period P, and output B rises exactly P>>1 clocks after output A rises.
- R2: In frequency mode the period P equals demand, clamped to the range t_min to t_max.
- R3: With demand < t_min (duty mode), P equals t_min and the on-time equals demand>>1, capped at (t_min>>1) - dead.
- R4: The two outputs are never high together, and every rise of one output follows at least dead low clocks after the fall of the other.
- R5: Burst is entered when, at a period boundary, the requested on-time demand>>1 is strictly less than th_off. While in burst both outputs and the trigger stay low. A request exactly equal to th_off keeps switching with on-time th_off.
- R6: Burst is left only when demand>>1 is strictly greater than th_on. A request between th_off and th_on, including exactly th_on, keeps the block in burst.
- R7: A new demand takes effect only at a period boundary, so the period in progress finishes with its old length.
- R8: adc_trig pulses once per switching period, high for one clock, (on-time>>1) clocks after output A rises, and only while output A is high.
- R9: One clock after fault is sampled high, both outputs and the trigger are low. They stay low after fault clears until en has been sampled low and then high again.
- R10: During reset and while en is low, both outputs are low. A rising en starts a period with output A high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; re-arm after a fault |
| fault | input | 1 | Protection trip, active high |
| demand | input | W | Regulator demand word |
| t_min | input | W | Shortest allowed period, clocks |
| t_max | input | W | Longest allowed period, clocks |
| th_off | input | W | On-time below which burst begins, clocks |
| th_on | input | W | On-time above which burst ends, clocks |
| dead | input | W | Minimum idle gap between the outputs, clocks |
| drive_a | output | 1 | First-half gate drive |
| drive_b | output | 1 | Second-half gate drive |
| adc_trig | output | 1 | One-clock sampling trigger |

## Verification
Two events can collide in a single clock. A fault can arrive in the very clock in which the sampling trigger would fire. A demand change can arrive while a period is still running. The bench times the fault so that it is sampled on the edge that would bring the counter to the trigger position, and then expects no trigger and both drives low. It also rewrites the demand ten clocks into a 100-clock period and counts the clocks to the next rise of output A, which must still be 100 before the new 60-clock period follows.

// File: rtl/llc_gate_drive.sv
module llc_gate_drive #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fault,
  input  logic [W-1:0] demand,
  input  logic [W-1:0] t_min,
  input  logic [W-1:0] t_max,
  input  logic [W-1:0] th_off,
  input  logic [W-1:0] th_on,
  input  logic [W-1:0] dead,
  output logic         drive_a,
  output logic         drive_b,
  output logic         adc_trig
);
  localparam logic [W-1:0] ONE = 1;

  logic         run, trip, brst;
  logic [W-1:0] cnt, per, on;

  wire         freq_mode = demand >= t_min;
  wire [W-1:0] per_n  = !freq_mode ? t_min : (demand > t_max ? t_max : demand);
  wire [W-1:0] half_n = per_n >> 1;
  wire [W-1:0] lim_n  = (half_n > dead) ? half_n - dead : '0;
  wire [W-1:0] req    = demand >> 1;
  wire [W-1:0] want_n = freq_mode ? half_n : (req < th_off ? th_off : req);
  wire [W-1:0] on_n   = (want_n > lim_n) ? lim_n : want_n;
  wire         held   = brst & run;
  wire         brst_n = !freq_mode && (held ? (req <= th_on) : (req < th_off));

  wire         stop   = fault | trip | !en;
  wire         wrap   = cnt == per - ONE;
  wire [W-1:0] half   = per >> 1;
  wire         active = run & ~brst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      trip <= 1'b0;
      brst <= 1'b0;
      cnt  <= '0;
      per  <= '0;
      on   <= '0;
    end else begin
      trip <= fault | (trip & en);
      if (stop) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (!run || wrap) begin
        run  <= 1'b1;
        cnt  <= '0;
        per  <= per_n;
        on   <= on_n;
        brst <= brst_n;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  assign drive_a  = active & (cnt < on);
  assign drive_b  = active & (cnt >= half) & ((cnt - half) < on);
  assign adc_trig = active & (on != '0) & (cnt == (on >> 1));
endmodule

// File: rtl/llc_gate_drive_chk.sv
module llc_gate_drive_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         fault,
  input logic [W-1:0] dead,
  input logic         drive_a,
  input logic         drive_b,
  input logic         adc_trig
);
  logic [W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (drive_a | drive_b) gap <= '0;
    else if (gap != '1) gap <= gap + 1'b1;
  end

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_a && drive_b));

  a_r4_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_b) |-> gap >= dead);

  a_r9_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!drive_a && !drive_b && !adc_trig));

  a_r8_trig_in_on: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> drive_a);

  a_r10_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drive_a && !drive_b));
endmodule

bind llc_gate_drive llc_gate_drive_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fault(fault), .dead(dead),
  .drive_a(drive_a), .drive_b(drive_b), .adc_trig(adc_trig)
);

// File: tb/llc_gate_drive_test.sv
module llc_gate_drive_test;
  localparam int CLK_P = 10;
  localparam int W = 12;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fault = 1'b0;
  logic [W-1:0] demand = 12'd100, t_min = 12'd40, t_max = 12'd140;
  logic [W-1:0] th_off = 12'd6, th_on = 12'd10, dead = 12'd3;
  logic drive_a, drive_b, adc_trig;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_per, m_ona, m_onb, m_offb, m_trg, m_ntrg;

  always #(CLK_P/2) clk = ~clk;

  llc_gate_drive #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .fault(fault), .demand(demand),
    .t_min(t_min), .t_max(t_max), .th_off(th_off), .th_on(th_on),
    .dead(dead), .drive_a(drive_a), .drive_b(drive_b), .adc_trig(adc_trig)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic pa = drive_a;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (drive_a && !pa) return;
      pa = drive_a;
    end
  endtask

  task automatic measure();
    logic pa;
    int i;
    wait_rise();
    m_ona = 0; m_onb = 0; m_offb = -1; m_trg = -1; m_ntrg = 0; i = 0;
    forever begin
      if (drive_a) m_ona++;
      if (drive_b) begin m_onb++; if (m_offb < 0) m_offb = i; end
      if (adc_trig) begin m_ntrg++; m_trg = i; end
      pa = drive_a;
      @(negedge clk);
      i++;
      if ((drive_a && !pa) || i > 5000) break;
    end
    m_per = i;
  endtask

  task automatic settle_measure(int d);
    demand = d[W-1:0];
    measure();
    measure();
  endtask

  task automatic quiet(string req, int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (drive_a || drive_b || adc_trig) hits++;
    end
    check(req, "active samples while off", hits, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10", "drive_a in reset", drive_a, 0);
    check("R10", "drive_b in reset", drive_b, 0);
    rst_n = 1'b1;
    quiet("R10", 20);
    en = 1'b1;
    @(negedge clk);
    check("R10", "drive_a after enable", drive_a, 1);
  endtask

  task automatic t_freq();
    settle_measure(100);
    check("R1", "period", m_per, 100);
    check("R1", "on A", m_ona, 47);
    check("R1", "on B", m_onb, 47);
    check("R1", "B offset", m_offb, 50);
    check("R8", "trigger offset", m_trg, 23);
    check("R8", "triggers per period", m_ntrg, 1);
  endtask

  task automatic t_clamp();
    settle_measure(300);
    check("R2", "clamped period", m_per, 140);
    check("R2", "clamped on", m_ona, 67);
    settle_measure(41);
    check("R2", "odd period", m_per, 41);
    check("R1", "odd on", m_ona, 17);
    check("R1", "odd B offset", m_offb, 20);
    check("R4", "B to A gap", m_per - (m_offb + m_onb), 4);
  endtask

  task automatic t_duty();
    settle_measure(30);
    check("R3", "duty period", m_per, 40);
    check("R3", "duty on A", m_ona, 15);
    check("R3", "duty on B", m_onb, 15);
    check("R8", "duty trigger", m_trg, 7);
    settle_measure(38);
    check("R3", "on capped by dead time", m_ona, 17);
    check("R4", "A to B gap", m_offb - m_ona, 3);
  endtask

  task automatic t_boundary();
    logic pa;
    int i = 0;
    settle_measure(100);
    wait_rise();
    forever begin
      pa = drive_a;
      @(negedge clk);
      i++;
      if (i == 10) demand = 12'd60;
      if ((drive_a && !pa) || i > 5000) break;
    end
    check("R7", "period in progress", i, 100);
    measure();
    check("R7", "next period", m_per, 60);
    check("R7", "next on", m_ona, 27);
  endtask

  task automatic t_burst();
    settle_measure(24);
    check("R6", "on before burst", m_ona, 12);
    settle_measure(12);
    check("R5", "on at th_off", m_ona, 6);
    demand = 12'd10;
    repeat (100) @(negedge clk);
    quiet("R5", 200);
    demand = 12'd16;
    quiet("R6", 200);
    demand = 12'd20;
    quiet("R6", 200);
    settle_measure(24);
    check("R6", "resumed on", m_ona, 12);
    check("R6", "resumed period", m_per, 40);
    check("R8", "resumed triggers", m_ntrg, 1);
  endtask

  task automatic t_fault();
    settle_measure(100);
    wait_rise();
    repeat (22) @(negedge clk);
    fault = 1'b1;
    @(negedge clk);
    check("R9", "drive_a after fault", drive_a, 0);
    check("R9", "trigger suppressed", adc_trig, 0);
    repeat (3) @(negedge clk);
    fault = 1'b0;
    quiet("R9", 300);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    measure();
    check("R9", "period after re-arm", m_per, 100);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_freq();
    t_clamp();
    t_duty();
    t_boundary();
    t_burst();
    t_fault();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule